// File: doc/BRIEF.md
# Event-Driven Semaphore Crediting Unit

This block lets external events wake tasks without any interrupt line. Each event input has its own target record, written through a configuration port. The record holds a node address, a resource number and a unit count. The block synchronizes every event input and looks for rising edges. On each edge it credits the configured number of units to the counting semaphore that the record points at.

When the node address equals the node's own address (`my_node`), the unit credits one of its local semaphore counters. When the address names another node, the block sends an outbound message carrying the node, resource and units. A message that cannot leave because the port is stalled stays pending. Further edges on the same input are added into that pending message.

Tasks queue on a local semaphore by giving a task number. Each semaphore keeps its own first-in first-out queue of waiting tasks. Whenever the count is non-zero, the oldest waiter is released and one unit is consumed.

Top module: `event_sem_unit`

## Requirements
- R1: After reset every semaphore count is 0, `msg_valid` is 0 and no `rel_valid` bit is set.
- R2: An event input is synchronized through two flops and acts only on a 0-to-1 transition. A change made before clock edge k is credited in the count visible after edge k+2. A level held high credits once, and a falling transition credits nothing.
- R3: A configuration write stores the target (`cfg_node`, `cfg_res`, `cfg_units`) for input `cfg_idx`. Later edges on that input use the new target.
- R4: An edge whose target node equals `my_node` adds its units to local semaphore number `res`. Edges from several inputs in the same cycle to one semaphore add up.
- R5: A local count saturates at 2^CNT_W-1 and never wraps.
- R6: An edge whose target node differs from `my_node` leaves every local count unchanged. It raises `msg_valid` with that node, resource and units, and the message holds its node and resource until accepted with `msg_ready`.
- R7: While an input's message is pending, further edges on that input add their units to it. The sum saturates at 2^UNIT_W-1.
- R8: When several inputs have messages pending, the lowest input index is sent first. A message already offered stays selected until it is accepted.
- R9: A wait request (`wait_valid`, `wait_sem`, `wait_task`) joins the queue of that semaphore. While the queue is non-empty and the count is non-zero, `rel_valid[s]` is 1 with the oldest task on `rel_task`. Each cycle it is 1, one waiter leaves and the count drops by one. This is at most one release per semaphore per cycle, in arrival order.
- R10: A wait request to a semaphore whose queue already holds Q_DEPTH tasks is dropped, and that task is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_node | input | NODE_W | Address of this node |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Event input whose target is written |
| cfg_node | input | NODE_W | Target node address |
| cfg_res | input | RES_W | Target semaphore number |
| cfg_units | input | UNIT_W | Units credited per edge |
| evt_in | input | N_EVT | Asynchronous event inputs |
| wait_valid | input | 1 | Wait request strobe |
| wait_sem | input | RES_W | Semaphore waited on |
| wait_task | input | TASK_W | Task number of the waiter |
| rel_valid | output | N_SEM | Release this cycle, one bit per semaphore |
| rel_task | output | N_SEM*TASK_W | Released task number, one field per semaphore |
| sem_count | output | N_SEM*CNT_W | Current count, one field per semaphore |
| msg_valid | output | 1 | Outbound update pending |
| msg_ready | input | 1 | Outbound port accepts the update |
| msg_node | output | NODE_W | Destination node of the update |
| msg_res | output | RES_W | Destination semaphore of the update |
| msg_units | output | UNIT_W | Units carried by the update |

## Verification
The hardest state to reach is a stalled outbound message that keeps growing. This needs several complete edges on one input while `msg_ready` is held low, followed by a pile-up of pending messages on different inputs. The bench reaches it by holding the port stalled and pulsing one remote input repeatedly until its sum saturates. It then raises two remote inputs in the same cycle and accepts one message per cycle to observe the order. The full-queue drop is reached by queuing more waiters than the depth on a semaphore at zero, then crediting it enough to release all of them and confirming that the extra task never appears.

// File: rtl/esu_pkg.sv
package esu_pkg;

   localparam int NODE_W = 4;
   localparam int RES_W  = 3;
   localparam int UNIT_W = 4;

   typedef struct packed {
      logic [NODE_W-1:0] node;
      logic [RES_W-1:0]  res;
      logic [UNIT_W-1:0] units;
   } evt_target_t;

   function automatic logic [UNIT_W-1:0] units_sat_add(input logic [UNIT_W-1:0] a,
                                                      input logic [UNIT_W-1:0] b);
      logic [UNIT_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[UNIT_W] ? {UNIT_W{1'b1}} : s[UNIT_W-1:0];
   endfunction

endpackage

// File: rtl/esu_edge_sync.sv
module esu_edge_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_in,
   output logic [N-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("esu_edge_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg [STAGES];
   logic [N-1:0] last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
         last <= '0;
      end else begin
         stg[0] <= async_in;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         last <= stg[STAGES-1];
      end
   end

   assign rise = stg[STAGES-1] & ~last;

   // R2: a detected rise is a single-cycle pulse per input
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/esu_outbox.sv
module esu_outbox import esu_pkg::*; #(
   parameter int N_EVT = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [N_EVT-1:0] fire,
   input  evt_target_t tgt [N_EVT],
   input  logic        msg_ready,
   output logic        msg_valid,
   output evt_target_t msg
);
   localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1;

   logic        pend_v [N_EVT];
   evt_target_t pend_t [N_EVT];
   logic             lock_v;
   logic [IDX_W-1:0] lock_idx, low_idx, sel;
   logic             sent;

   always_comb begin
      low_idx   = '0;
      msg_valid = 1'b0;
      for (int i = N_EVT - 1; i >= 0; i--) begin
         if (pend_v[i]) begin
            low_idx   = IDX_W'(i);
            msg_valid = 1'b1;
         end
      end
   end

   assign sel  = lock_v ? lock_idx : low_idx;
   assign msg  = pend_t[sel];
   assign sent = msg_valid && msg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_v   <= 1'b0;
         lock_idx <= '0;
      end else begin
         lock_v   <= msg_valid && !msg_ready;
         lock_idx <= sel;
      end
   end

   for (genvar g = 0; g < N_EVT; g++) begin : g_pend
      logic taken;
      assign taken = sent && (sel == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_v[g] <= 1'b0;
            pend_t[g] <= '0;
         end else if (taken) begin
            pend_v[g] <= fire[g];
            pend_t[g] <= tgt[g];
         end else if (fire[g]) begin
            if (pend_v[g]) begin
               pend_t[g].units <= units_sat_add(pend_t[g].units, tgt[g].units);
            end else begin
               pend_v[g] <= 1'b1;
               pend_t[g] <= tgt[g];
            end
         end
      end
   end

   // R6: an offered update keeps its destination until accepted
   p_hold_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg.node) && $stable(msg.res)));

   // R7: a stalled update only grows
   p_units_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg.units >= $past(msg.units)));

   // R8: a stalled selection is locked to the same input
   p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (sel == $past(sel)));

endmodule

// File: rtl/esu_sem_slot.sv
module esu_sem_slot #(
   parameter int CNT_W   = 8,
   parameter int TASK_W  = 5,
   parameter int Q_DEPTH = 4,
   parameter int CRED_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CRED_W-1:0] credit,
   input  logic              enq,
   input  logic [TASK_W-1:0] enq_task,
   output logic              rel_valid,
   output logic [TASK_W-1:0] rel_task,
   output logic [CNT_W-1:0]  count
);
   localparam int PTR_W  = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
   localparam int FILL_W = $clog2(Q_DEPTH + 1);
   localparam int SUM_W  = ((CNT_W > CRED_W) ? CNT_W : CRED_W) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (Q_DEPTH < 2 || (1 << PTR_W) != Q_DEPTH) begin : g_bad_depth
      $error("esu_sem_slot: Q_DEPTH must be a power of two, at least 2");
   end

   logic [TASK_W-1:0] q_mem [Q_DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [FILL_W-1:0] fill;
   logic              full, do_enq;
   logic [SUM_W-1:0]  sum;

   assign full      = (fill == FILL_W'(Q_DEPTH));
   assign do_enq    = enq && !full;
   assign rel_valid = (fill != '0) && (count != '0);
   assign rel_task  = q_mem[rd_ptr];

   always_comb begin
      sum = SUM_W'(count) - SUM_W'(rel_valid) + SUM_W'(credit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill   <= '0;
         count  <= '0;
      end else begin
         if (do_enq)    wr_ptr <= wr_ptr + 1'b1;
         if (rel_valid) rd_ptr <= rd_ptr + 1'b1;
         fill  <= fill + FILL_W'(do_enq) - FILL_W'(rel_valid);
         count <= (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (do_enq) q_mem[wr_ptr] <= enq_task;
   end

   // R5: a full counter stays full without a release
   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !rel_valid) |=> (count == CNT_MAX));

   // R9: a release with no credit consumes exactly one unit
   p_consume_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && credit == '0) |=> (count == $past(count) - 1'b1));

   // R10: a request to a full queue leaves the occupancy unchanged
   p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enq && full && !rel_valid) |=> (fill == $past(fill)));

endmodule

// File: rtl/event_sem_unit.sv
module event_sem_unit import esu_pkg::*; #(
   parameter int N_EVT       = 4,
   parameter int N_SEM       = 4,
   parameter int CNT_W       = 8,
   parameter int TASK_W      = 5,
   parameter int Q_DEPTH     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NODE_W-1:0]       my_node,
   input  logic                    cfg_we,
   input  logic [IDX_W-1:0]        cfg_idx,
   input  logic [NODE_W-1:0]       cfg_node,
   input  logic [RES_W-1:0]        cfg_res,
   input  logic [UNIT_W-1:0]       cfg_units,
   input  logic [N_EVT-1:0]        evt_in,
   input  logic                    wait_valid,
   input  logic [RES_W-1:0]        wait_sem,
   input  logic [TASK_W-1:0]       wait_task,
   output logic [N_SEM-1:0]        rel_valid,
   output logic [N_SEM*TASK_W-1:0] rel_task,
   output logic [N_SEM*CNT_W-1:0]  sem_count,
   output logic                    msg_valid,
   input  logic                    msg_ready,
   output logic [NODE_W-1:0]       msg_node,
   output logic [RES_W-1:0]        msg_res,
   output logic [UNIT_W-1:0]       msg_units
);
   localparam int CRED_W = UNIT_W + $clog2(N_EVT + 1);

   if (N_EVT < 2) begin : g_bad_evt
      $error("event_sem_unit: N_EVT must be at least 2");
   end
   if (N_SEM < 1 || N_SEM > (1 << RES_W)) begin : g_bad_sem
      $error("event_sem_unit: N_SEM must fit the resource field");
   end

   evt_target_t       cfg_tab [N_EVT];
   logic [N_EVT-1:0]  fire, is_local, fire_remote;
   logic [CRED_W-1:0] credit [N_SEM];
   evt_target_t       msg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_EVT; i++) cfg_tab[i] <= '0;
      end else begin
         for (int i = 0; i < N_EVT; i++) begin
            if (cfg_we && cfg_idx == IDX_W'(i)) begin
               cfg_tab[i] <= '{node: cfg_node, res: cfg_res, units: cfg_units};
            end
         end
      end
   end

   esu_edge_sync #(.N(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (evt_in),
      .rise     (fire)
   );

   always_comb begin
      for (int i = 0; i < N_EVT; i++) is_local[i] = (cfg_tab[i].node == my_node);
      fire_remote = fire & ~is_local;
      for (int s = 0; s < N_SEM; s++) begin
         credit[s] = '0;
         for (int i = 0; i < N_EVT; i++) begin
            if (fire[i] && is_local[i] && cfg_tab[i].res == RES_W'(s)) begin
               credit[s] = credit[s] + CRED_W'(cfg_tab[i].units);
            end
         end
      end
   end

   esu_outbox #(.N_EVT(N_EVT)) u_outbox (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire_remote),
      .tgt       (cfg_tab),
      .msg_ready (msg_ready),
      .msg_valid (msg_valid),
      .msg       (msg)
   );

   assign msg_node  = msg.node;
   assign msg_res   = msg.res;
   assign msg_units = msg.units;

   for (genvar s = 0; s < N_SEM; s++) begin : g_sem
      logic enq;
      assign enq = wait_valid && (wait_sem == RES_W'(s));
      esu_sem_slot #(
         .CNT_W   (CNT_W),
         .TASK_W  (TASK_W),
         .Q_DEPTH (Q_DEPTH),
         .CRED_W  (CRED_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .credit    (credit[s]),
         .enq       (enq),
         .enq_task  (wait_task),
         .rel_valid (rel_valid[s]),
         .rel_task  (rel_task[s*TASK_W +: TASK_W]),
         .count     (sem_count[s*CNT_W +: CNT_W])
      );
   end

   // R6: remote-only edges never move a local count
   p_remote_no_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((fire & is_local) == '0 && rel_valid == '0) |=> $stable(sem_count));

endmodule

// File: tb/event_sem_unit_bench.sv
module event_sem_unit_bench;
   localparam int N_EVT = 4, N_SEM = 4, CNT_W = 8, TASK_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] my_node = 4'd5;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [3:0] cfg_node = '0;
   logic [2:0] cfg_res = '0;
   logic [3:0] cfg_units = '0;
   logic [N_EVT-1:0] evt_in = '0;
   logic wait_valid = 1'b0;
   logic [2:0] wait_sem = '0;
   logic [TASK_W-1:0] wait_task = '0;
   logic [N_SEM-1:0] rel_valid;
   logic [N_SEM*TASK_W-1:0] rel_task;
   logic [N_SEM*CNT_W-1:0] sem_count;
   logic msg_valid, msg_ready = 1'b0;
   logic [3:0] msg_node;
   logic [2:0] msg_res;
   logic [3:0] msg_units;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   event_sem_unit u_event_sem_unit (
      .clk(clk), .rst_n(rst_n), .my_node(my_node),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_node(cfg_node), .cfg_res(cfg_res), .cfg_units(cfg_units),
      .evt_in(evt_in), .wait_valid(wait_valid), .wait_sem(wait_sem), .wait_task(wait_task),
      .rel_valid(rel_valid), .rel_task(rel_task), .sem_count(sem_count),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node), .msg_res(msg_res), .msg_units(msg_units)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int cnt(input int s);
      return int'(sem_count[s*CNT_W +: CNT_W]);
   endfunction

   function automatic int task_of(input int s);
      return int'(rel_task[s*TASK_W +: TASK_W]);
   endfunction

   task automatic set_target(input int idx, input int node, input int res, input int units);
      cfg_idx = 2'(idx); cfg_node = 4'(node); cfg_res = 3'(res); cfg_units = 4'(units);
      cfg_we = 1'b1;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input int idx);
      evt_in[idx] = 1'b1;
      tick(3);
      evt_in[idx] = 1'b0;
      tick(3);
   endtask

   task automatic t_reset;
      for (int s = 0; s < N_SEM; s++) check("R1 count", cnt(s), 0);
      check("R1 msg_valid", int'(msg_valid), 0);
      check("R1 rel_valid", int'(rel_valid), 0);
   endtask

   task automatic t_local_edge;
      set_target(0, 5, 1, 3);
      evt_in[0] = 1'b1;
      tick(2);
      check("R2 not yet credited", cnt(1), 0);
      tick(1);
      check("R2 R3 credited at third edge", cnt(1), 3);
      tick(5);
      check("R2 level held credits once", cnt(1), 3);
      evt_in[0] = 1'b0;
      tick(4);
      check("R2 falling edge no credit", cnt(1), 3);
   endtask

   task automatic t_sum;
      set_target(1, 5, 1, 4);
      set_target(2, 5, 2, 2);
      evt_in[2:0] = 3'b111;
      tick(3);
      check("R4 same-cycle sum", cnt(1), 10);
      check("R4 other semaphore", cnt(2), 2);
      evt_in[2:0] = 3'b000;
      tick(3);
   endtask

   task automatic t_saturate;
      set_target(3, 5, 3, 15);
      for (int k = 0; k < 16; k++) pulse(3);
      check("R5 below max", cnt(3), 240);
      pulse(3);
      check("R5 reaches max", cnt(3), 255);
      pulse(3);
      check("R5 no wrap", cnt(3), 255);
   endtask

   task automatic t_wait_release;
      wait_valid = 1'b1; wait_sem = 3'd1; wait_task = 5'd7;
      tick(1);
      check("R9 release offered", int'(rel_valid[1]), 1);
      check("R9 task reported", task_of(1), 7);
      wait_task = 5'd9;
      tick(1);
      check("R9 count decremented", cnt(1), 9);
      check("R9 second waiter task", task_of(1), 9);
      wait_valid = 1'b0;
      tick(1);
      check("R9 count after two", cnt(1), 8);
      check("R9 queue empty", int'(rel_valid[1]), 0);
   endtask

   task automatic t_queue_full;
      int tasks[5] = '{3, 4, 5, 6, 8};
      wait_valid = 1'b1; wait_sem = 3'd0;
      for (int k = 0; k < 5; k++) begin
         wait_task = 5'(tasks[k]);
         tick(1);
      end
      wait_valid = 1'b0;
      check("R9 no release at zero", int'(rel_valid[0]), 0);
      set_target(0, 5, 0, 15);
      evt_in[0] = 1'b1;
      tick(3);
      for (int k = 0; k < 4; k++) begin
         check("R9 fifo order valid", int'(rel_valid[0]), 1);
         check("R9 fifo order task", task_of(0), tasks[k]);
         check("R9 count", cnt(0), 15 - k);
         tick(1);
      end
      check("R10 dropped task not released", int'(rel_valid[0]), 0);
      check("R10 count after four", cnt(0), 11);
      evt_in[0] = 1'b0;
      tick(3);
   endtask

   task automatic t_remote;
      set_target(2, 9, 6, 5);
      pulse(2);
      check("R6 msg_valid", int'(msg_valid), 1);
      check("R6 msg_node", int'(msg_node), 9);
      check("R6 msg_res", int'(msg_res), 6);
      check("R6 msg_units", int'(msg_units), 5);
      check("R6 local count untouched", cnt(2), 2);
      pulse(2);
      check("R7 accumulated", int'(msg_units), 10);
      check("R6 node held", int'(msg_node), 9);
      pulse(2);
      pulse(2);
      check("R7 saturated", int'(msg_units), 15);
      msg_ready = 1'b1;
      tick(1);
      msg_ready = 1'b0;
      check("R6 cleared after accept", int'(msg_valid), 0);
   endtask

   task automatic t_order;
      set_target(1, 9, 1, 1);
      set_target(3, 10, 2, 7);
      evt_in[1] = 1'b1; evt_in[3] = 1'b1;
      tick(3);
      evt_in[1] = 1'b0; evt_in[3] = 1'b0;
      check("R8 lowest first node", int'(msg_node), 9);
      check("R8 lowest first units", int'(msg_units), 1);
      msg_ready = 1'b1;
      tick(1);
      check("R8 second valid", int'(msg_valid), 1);
      check("R8 second node", int'(msg_node), 10);
      check("R8 second units", int'(msg_units), 7);
      tick(1);
      msg_ready = 1'b0;
      check("R8 all sent", int'(msg_valid), 0);
      tick(3);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_local_edge();
      t_sum();
      t_saturate();
      t_wait_release();
      t_queue_full();
      t_remote();
      t_order();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule